// File: doc/BRIEF.md
# Linked-List Schedule Sequencer

This block steps a statically scheduled router through its routing program. A small schedule store is read once per clock. Each stored entry names the virtual state machine (a 5-bit index) that every pipeline should run on the cycle, and it also holds the address of the entry to fetch next. The schedule is therefore a linked list rather than a counted sequence. The per-pipeline indices are registered and passed on to the following pipeline stage, where the annotation lookup happens.

The program is changed at run time through one write port. A write can replace any stored entry, or it can force the address that is fetched next. Only writes tagged as coming from pipeline zero are taken; writes from any other pipeline are dropped. If the link fields are arranged so that each equal-sized region of the store points to its own next slot and wraps at the region end, the store holds several independent looping schedules. A pointer load then selects which loop runs.

Top module: `sched_seq`

## Requirements
- R1: While reset is held and until the first fetch after reset completes, `out_valid` is 0 and every lane of `out_idx` equals `IDLE_IDX`. The fetch address after reset is 0.
- R2: Reset fills every entry `a` with `IDLE_IDX` in all lanes and link `(a+1) mod DEPTH`, so entry DEPTH-1 links to entry 0.
- R3: An entry fetched at a clock edge appears on `out_idx` just after that edge. Pipeline lane `p` of `out_idx` is bits `[p*IDX_W +: IDX_W]`.
- R4: Without a pointer load, the address fetched at each edge is the link field of the entry fetched at the previous edge.
- R5: An entry word is laid out as link in bits `[ADDR_W-1:0]` and lane `p` in bits `[ADDR_W+p*IDX_W +: IDX_W]`. With `wr_kind`=0, an accepted write stores `wr_data` at `wr_addr`.
- R6: With `wr_kind`=1, an accepted write makes `wr_addr` the address fetched at the next edge. This overrides the link field of the entry fetched at the current edge.
- R7: A write with `wr_pipe` other than 0 changes neither the store nor the fetch address.
- R8: When an entry is written on the same edge at which it is fetched, the output shows the old contents and the old link. The new contents are seen from the next fetch of that entry.
- R9: Equal-sized regions whose links run in order and wrap at the region end loop independently. A pointer load into a region keeps the sequencer cycling inside it.
- R10: Once `out_valid` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Reprogramming write request |
| wr_pipe | input | PIPE_W | Pipeline issuing the write |
| wr_kind | input | 1 | 0 = entry write, 1 = pointer load |
| wr_addr | input | ADDR_W | Entry address or new pointer value |
| wr_data | input | ADDR_W+N_PIPES*IDX_W | Entry contents (link and lanes) |
| out_valid | output | 1 | A fetch has completed since reset |
| out_idx | output | N_PIPES*IDX_W | Per-pipeline state machine indices |

## Verification
The bench builds the block with three pipelines, 128 entries and `IDLE_IDX` set to 31. With three pipelines, `wr_pipe` is 2 bits wide, so rejected writes from pipelines 1 and 2 can be issued. An idle value of 31 cannot be mistaken for the small indices the bench programs. The full 128-entry depth brings the wrap from entry 127 back to entry 0 within reach. Two 4- and 2-entry loops are programmed while the sequencer runs, so writes land on entries both ahead of and at the current fetch.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    WK_ENTRY = 1'b0,
    WK_PTR   = 1'b1
  } wr_kind_e;

  function automatic int wrap_inc(input int a, input int depth);
    return (a + 1 == depth) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/sched_wr_dec.sv
module sched_wr_dec #(
  parameter int PIPE_W = 1
) (
  input  logic              wr_valid,
  input  logic [PIPE_W-1:0] wr_pipe,
  input  logic              wr_kind,
  output logic              entry_we,
  output logic              ptr_load
);
  import sched_pkg::*;
  logic from_zero;

  always_comb begin
    from_zero = (wr_pipe == '0);
    entry_we  = wr_valid && from_zero && (wr_kind == WK_ENTRY);
    ptr_load  = wr_valid && from_zero && (wr_kind == WK_PTR);
  end
endmodule

// File: rtl/sched_mem.sv
module sched_mem #(
  parameter int ADDR_W  = 7,
  parameter int N_PIPES = 2,
  parameter int IDX_W   = 5,
  parameter logic [IDX_W-1:0] IDLE_IDX = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [ADDR_W+N_PIPES*IDX_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]                 raddr,
  output logic [ADDR_W+N_PIPES*IDX_W-1:0]   rdata
);
  import sched_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int EW    = ADDR_W + N_PIPES * IDX_W;

  logic [EW-1:0] store [DEPTH];

  function automatic logic [EW-1:0] reset_entry(input int a);
    return {{N_PIPES{IDLE_IDX}}, ADDR_W'(wrap_inc(a, DEPTH))};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) store[a] <= reset_entry(a);
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/sched_ptr.sv
module sched_ptr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else           addr <= link;
  end
endmodule

// File: rtl/sched_out.sv
module sched_out #(
  parameter int N_PIPES = 2,
  parameter int IDX_W   = 5,
  parameter logic [IDX_W-1:0] IDLE_IDX = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PIPES*IDX_W-1:0] lanes,
  output logic                     valid,
  output logic [N_PIPES*IDX_W-1:0] idx
);
  for (genvar p = 0; p < N_PIPES; p++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx[p*IDX_W +: IDX_W] <= IDLE_IDX;
      else        idx[p*IDX_W +: IDX_W] <= lanes[p*IDX_W +: IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= 1'b1;
  end
endmodule

// File: rtl/sched_seq.sv
module sched_seq #(
  parameter int N_PIPES = 2,
  parameter int ADDR_W  = 7,
  parameter int IDX_W   = 5,
  parameter logic [IDX_W-1:0] IDLE_IDX = '0,
  localparam int PIPE_W = (N_PIPES > 1) ? $clog2(N_PIPES) : 1,
  localparam int EW     = ADDR_W + N_PIPES * IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [PIPE_W-1:0]        wr_pipe,
  input  logic                     wr_kind,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [EW-1:0]            wr_data,
  output logic                     out_valid,
  output logic [N_PIPES*IDX_W-1:0] out_idx
);
  logic              entry_we;
  logic              ptr_load;
  logic [ADDR_W-1:0] rd_addr;
  logic [EW-1:0]     rd_data;
  logic [ADDR_W-1:0] link_next;

  assign link_next = rd_data[ADDR_W-1:0];

  sched_wr_dec #(.PIPE_W(PIPE_W)) u_dec (
    .wr_valid(wr_valid), .wr_pipe(wr_pipe), .wr_kind(wr_kind),
    .entry_we(entry_we), .ptr_load(ptr_load)
  );

  sched_mem #(.ADDR_W(ADDR_W), .N_PIPES(N_PIPES), .IDX_W(IDX_W), .IDLE_IDX(IDLE_IDX)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(entry_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  sched_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_addr(wr_addr),
    .link(link_next), .addr(rd_addr)
  );

  sched_out #(.N_PIPES(N_PIPES), .IDX_W(IDX_W), .IDLE_IDX(IDLE_IDX)) u_out (
    .clk(clk), .rst_n(rst_n), .lanes(rd_data[EW-1:ADDR_W]),
    .valid(out_valid), .idx(out_idx)
  );
endmodule

// File: rtl/sched_seq_chk.sv
module sched_seq_chk #(
  parameter int N_PIPES = 2,
  parameter int ADDR_W  = 7,
  parameter int IDX_W   = 5,
  parameter logic [IDX_W-1:0] IDLE_IDX = '0,
  parameter int PIPE_W  = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic [PIPE_W-1:0]        wr_pipe,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     entry_we,
  input logic                     ptr_load,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [ADDR_W-1:0]        link_next,
  input logic                     out_valid,
  input logic [N_PIPES*IDX_W-1:0] out_idx
);
  // R1: idle indices until the first fetch completes
  a_r1_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_idx == {N_PIPES{IDLE_IDX}});

  // R4: fetch address follows the link of the previous entry
  a_r4_follow_link: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_load |=> rd_addr == $past(link_next));

  // R6: a pointer load decides the next fetch address
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> rd_addr == $past(wr_addr));

  // R7: other pipelines cannot reprogram
  a_r7_pipe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_pipe != '0) |-> (!ptr_load && !entry_we));

  // R10: valid never drops outside reset
  a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

bind sched_seq sched_seq_chk #(
  .N_PIPES(N_PIPES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDLE_IDX(IDLE_IDX), .PIPE_W(PIPE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_pipe(wr_pipe), .wr_addr(wr_addr),
  .entry_we(entry_we), .ptr_load(ptr_load), .rd_addr(rd_addr), .link_next(link_next),
  .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/tb_sched_seq.sv
`timescale 1ns/1ps
module tb_sched_seq;
  localparam int NP = 3;
  localparam int AW = 7;
  localparam int IW = 5;
  localparam int PW = 2;
  localparam int EW = AW + NP * IW;
  localparam int DEPTH = 1 << AW;
  localparam logic [IW-1:0] IDLE = 5'd31;
  localparam int VW = 1 + PW + 1 + AW + EW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [PW-1:0] wr_pipe = '0;
  logic wr_kind = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [EW-1:0] wr_data = '0;
  logic out_valid;
  logic [NP*IW-1:0] out_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sched_seq #(.N_PIPES(NP), .ADDR_W(AW), .IDX_W(IW), .IDLE_IDX(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_pipe(wr_pipe), .wr_kind(wr_kind),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid), .out_idx(out_idx)
  );

  function automatic logic [EW-1:0] ent(int l2, int l1, int l0, int nxt);
    return {IW'(l2), IW'(l1), IW'(l0), AW'(nxt)};
  endfunction

  function automatic logic [VW-1:0] vec(bit v, int pipe, bit kind, int addr, logic [EW-1:0] d);
    return {v, PW'(pipe), kind, AW'(addr), d};
  endfunction

  localparam int NV = 24;
  localparam logic [VW-1:0] VECS [NV] = '{
    vec(1, 0, 0, 0, ent(3, 2, 1, 1)),
    vec(1, 0, 0, 1, ent(6, 5, 4, 2)),
    vec(1, 0, 0, 2, ent(9, 8, 7, 3)),
    vec(1, 0, 0, 3, ent(12, 11, 10, 0)),
    vec(1, 0, 0, 4, ent(15, 14, 13, 5)),
    vec(1, 0, 0, 5, ent(18, 17, 16, 4)),
    vec(1, 0, 1, 0, '0),
    vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0),
    vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0),
    vec(1, 0, 1, 4, '0),
    vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0),
    vec(1, 1, 1, 0, '0),
    vec(1, 2, 0, 4, ent(1, 1, 1, 9)),
    vec(1, 3, 1, 2, '0),
    vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0), vec(0, 0, 0, 0, '0)
  };

  // bench-side picture of the schedule store and fetch address
  logic [EW-1:0] mm [DEPTH];
  int mp;

  task automatic check(bit cond, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [PW-1:0] pipe, bit kind, logic [AW-1:0] addr,
                      logic [EW-1:0] d, string req);
    logic [EW-1:0] cur;
    wr_valid = v; wr_pipe = pipe; wr_kind = kind; wr_addr = addr; wr_data = d;
    cur = mm[mp];
    @(posedge clk);
    if (v && pipe == 0 && kind) mp = int'(addr);
    else                        mp = int'(cur[AW-1:0]);
    if (v && pipe == 0 && !kind) mm[addr] = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(out_idx == cur[EW-1:AW], req, "out_idx", 64'(out_idx), 64'(cur[EW-1:AW]));
    check(out_valid == 1'b1, "R10", "out_valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mm[a] = {{NP{IDLE}}, AW'((a + 1) % DEPTH)};
    mp = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
    check(out_idx == {NP{IDLE}}, "R1", "idle in reset", 64'(out_idx), 64'({NP{IDLE}}));
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0, "R1", "valid before fetch", 64'(out_valid), 64'd0);
    check(out_idx == {NP{IDLE}}, "R1", "idle before fetch", 64'(out_idx), 64'({NP{IDLE}}));
    @(negedge clk);
    // R2: reset contents walked in order
    step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 0, 0, '0, "R2");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] r;
      string tag;
      r = VECS[i];
      if (i < 6)        tag = "R5";
      else if (i < 13)  tag = "R9 R4";
      else if (i < 18)  tag = "R9 R6";
      else if (i < 21)  tag = "R7";
      else              tag = "R3";
      step(r[VW-1], r[VW-2 -: PW], r[VW-PW-2], r[EW +: AW], r[EW-1:0], tag);
    end

    // R8: write the entry being fetched on the same edge
    step(1, 0, 0, AW'(mp), ent(22, 21, 20, mp), "R8");
    step(0, 0, 0, 0, '0, "R8");
    step(1, 0, 1, 7'd4, '0, "R8");
    step(0, 0, 0, 0, '0, "R8");
    step(0, 0, 0, 0, '0, "R8");
    // R8: revisit after the rewrite through the loop
    step(0, 0, 0, 0, '0, "R8");
    step(0, 0, 0, 0, '0, "R8");

    // R2: last entry wraps to entry 0
    step(1, 0, 1, 7'd127, '0, "R6");
    step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 0, 0, '0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule